// File: doc/BRIEF.md
# Banked Operand Collector for Vector ALU Instructions

This block sits between the instruction scheduler and a vector ALU. It holds vector ALU instructions in an in-order queue. For each instruction it gathers up to three vector source operands, then hands the complete instruction to the ALU. The vector register file behind it is split into four banks, and each bank answers one read per cycle. When several waiting operands need the same bank in one cycle, they are served one after another, so a bank conflict costs extra cycles for the operands involved. It does not stall the whole front end.

A register file cache is looked up at the moment an instruction enters. A source that hits is taken straight from the cache and never reaches a bank. A source whose valid bit is clear is not read at all. The block also counts the cycles in which a pending bank read had to wait. This lets register layouts that conflict on banks be compared against layouts that do not.

Top module: `opc_collector`

## Requirements
- R1: A register index maps to bank `index[1:0]` (index mod 4), and the row sent on that bank's read port is `index[8:2]`.
- R2: Each bank port issues at most one read per cycle. A pending read that loses arbitration stays pending and is tried again in later cycles.
- R3: When several pending reads target one bank, the read belonging to the oldest queued instruction wins. Within one instruction, source slot 0 beats slot 1, and slot 1 beats slot 2.
- R4: A valid source with `rfc_hit` set on its slot when the instruction is accepted takes its operand from that slot of `rfc_data` and never causes a bank read.
- R5: A valid source that misses in the cache requests its bank no earlier than the cycle after acceptance. The bank data returns in the cycle after the request and becomes that slot's operand.
- R6: A source with its `in_src_vld` bit clear needs no read, and its slot of `out_ops` is zero.
- R7: `out_valid` is high only when the oldest queued instruction has all of its operands. Instructions leave in acceptance order. While `out_ready` is low, `out_valid` and `out_tag` hold.
- R8: `in_ready` is low when DEPTH instructions are queued, unless the oldest one issues in that same cycle. In that case a new instruction is accepted in the same cycle.
- R9: `conflict_cycles` is zero after reset. It rises by exactly one in each cycle in which at least one pending bank read is not granted, and otherwise holds.
- R10: After reset the queue is empty: `in_ready` is 1, `out_valid` is 0 and no bank read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | New instruction offered |
| in_ready | output | 1 | Instruction can be accepted this cycle |
| in_tag | input | TAG_W | Identifier carried with the instruction |
| in_src_vld | input | NSRC | Per-slot source used flag |
| in_src_idx | input | NSRC*IDX_W | Per-slot source register index, slot 0 in low bits |
| rfc_hit | input | NSRC | Per-slot cache hit for the offered indices |
| rfc_data | input | NSRC*VW | Per-slot cache data for the offered indices |
| bank_rd_en | output | NBANKS | Per-bank read request |
| bank_rd_idx | output | NBANKS*ROW_W | Per-bank row to read |
| bank_rd_data | input | NBANKS*VW | Per-bank read data, one cycle after the request |
| out_valid | output | 1 | Oldest instruction complete and offered to the ALU |
| out_ready | input | 1 | ALU accepts the offered instruction |
| out_tag | output | TAG_W | Identifier of the offered instruction |
| out_ops | output | NSRC*VW | Operands of the offered instruction, slot 0 in low bits |
| conflict_cycles | output | CNT_W | Cycles in which a bank read had to wait |

## Verification
The bench builds the block with two lanes of eight bits, so each register value is 16 bits wide. It keeps the full 512-register space, four banks and a four-deep queue. Because the operands are narrow, every bank value can be an odd-multiplier function of its register index, and every cache value can be its inverse. A wrong bank, a wrong row or a leak from the cache therefore shows up directly in the issued operands. The shallow queue fills within a few cycles, so the full-queue stall, same-cycle accept-and-issue and four-way bank pile-ups are all reached often during the long mixed-traffic run.

// File: rtl/opc_pkg.sv
package opc_pkg;

    // Life cycle of one operand slot inside a queue entry.
    typedef enum logic [1:0] {
        SLOT_READY = 2'd0,  // operand present, or no operand needed
        SLOT_NEED  = 2'd1,  // waiting for a bank grant
        SLOT_INFL  = 2'd2   // bank read granted, data arrives next edge
    } slot_st_e;

    // Default operand slots per instruction.
    localparam int OPC_NSRC = 3;

    // Flat request position of (age, slot) within a bank's request vector.
    function automatic int req_pos(input int age, input int slot, input int nsrc);
        return age * nsrc + slot;
    endfunction

endpackage

// File: rtl/opc_bank_arb.sv
module opc_bank_arb #(
    parameter int N = 12
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    // Lowest position wins; positions are ordered oldest entry first, then slot.
    always_comb begin
        gnt = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) begin
                gnt    = '0;
                gnt[k] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/opc_conflict_cnt.sv
module opc_conflict_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lost,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (lost) cnt <= cnt + 1'b1;
    end

    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !lost |=> $stable(cnt)); // R9
    AST_CNT_BUMP: assert property (@(posedge clk) disable iff (rst)
        lost |=> cnt != $past(cnt)); // R9
endmodule

// File: rtl/opc_collector.sv
module opc_collector
    import opc_pkg::*;
#(
    parameter int LANES  = 64,
    parameter int LANE_W = 32,
    parameter int NREGS  = 512,
    parameter int NBANKS = 4,
    parameter int NSRC   = OPC_NSRC,
    parameter int DEPTH  = 4,
    parameter int TAG_W  = 8,
    parameter int CNT_W  = 16,
    localparam int VW     = LANES * LANE_W,
    localparam int IDX_W  = $clog2(NREGS),
    localparam int BANK_W = $clog2(NBANKS),
    localparam int ROW_W  = IDX_W - BANK_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [TAG_W-1:0]        in_tag,
    input  logic [NSRC-1:0]         in_src_vld,
    input  logic [NSRC*IDX_W-1:0]   in_src_idx,
    input  logic [NSRC-1:0]         rfc_hit,
    input  logic [NSRC*VW-1:0]      rfc_data,
    output logic [NBANKS-1:0]       bank_rd_en,
    output logic [NBANKS*ROW_W-1:0] bank_rd_idx,
    input  logic [NBANKS*VW-1:0]    bank_rd_data,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [TAG_W-1:0]        out_tag,
    output logic [NSRC*VW-1:0]      out_ops,
    output logic [CNT_W-1:0]        conflict_cycles
);
    localparam int PTR_W = $clog2(DEPTH);   // DEPTH: power of two, at least 2
    localparam int NREQ  = DEPTH * NSRC;

    logic [PTR_W-1:0] head_q, tail_q;
    logic [PTR_W:0]   count_q;
    slot_st_e         st_q  [DEPTH][NSRC];
    logic [IDX_W-1:0] idx_q [DEPTH][NSRC];
    logic [VW-1:0]    dat_q [DEPTH][NSRC];
    logic [TAG_W-1:0] tag_q [DEPTH];

    logic [NREQ-1:0]  req_v [NBANKS];
    logic [NREQ-1:0]  gnt_v [NBANKS];
    logic [NSRC-1:0]  gnt_slot [DEPTH];
    logic             head_done, issue, accept, lost;

    // Build per-bank request vectors in age order starting at the head.
    always_comb begin
        logic [PTR_W-1:0] ph;
        for (int b = 0; b < NBANKS; b++) begin
            req_v[b] = '0;
            for (int a = 0; a < DEPTH; a++) begin
                ph = head_q + PTR_W'(a);
                for (int s = 0; s < NSRC; s++) begin
                    req_v[b][req_pos(a, s, NSRC)] = (st_q[ph][s] == SLOT_NEED) &&
                        (idx_q[ph][s][BANK_W-1:0] == BANK_W'(b));
                end
            end
        end
    end

    generate
        for (genvar b = 0; b < NBANKS; b++) begin : g_bank
            opc_bank_arb #(.N(NREQ)) u_arb (
                .req (req_v[b]),
                .gnt (gnt_v[b])
            );
            assign bank_rd_en[b] = |gnt_v[b];

            AST_ONE_READ_PER_BANK: assert property (@(posedge clk) disable iff (rst)
                $onehot0(gnt_v[b])); // R2
            AST_GRANT_WAS_PENDING: assert property (@(posedge clk) disable iff (rst)
                (gnt_v[b] & ~req_v[b]) == '0); // R2
        end
    endgenerate

    // Map grants back onto physical slots and drive the row of each bank.
    always_comb begin
        logic [PTR_W-1:0] ph;
        bank_rd_idx = '0;
        for (int e = 0; e < DEPTH; e++) gnt_slot[e] = '0;
        for (int b = 0; b < NBANKS; b++) begin
            for (int a = 0; a < DEPTH; a++) begin
                ph = head_q + PTR_W'(a);
                for (int s = 0; s < NSRC; s++) begin
                    if (gnt_v[b][req_pos(a, s, NSRC)]) begin
                        gnt_slot[ph][s] = 1'b1;
                        bank_rd_idx[b*ROW_W +: ROW_W] = idx_q[ph][s][IDX_W-1:BANK_W];
                    end
                end
            end
        end
    end

    always_comb begin
        lost = 1'b0;
        for (int e = 0; e < DEPTH; e++)
            for (int s = 0; s < NSRC; s++)
                if (st_q[e][s] == SLOT_NEED && !gnt_slot[e][s]) lost = 1'b1;
    end

    always_comb begin
        head_done = 1'b1;
        for (int s = 0; s < NSRC; s++)
            if (st_q[head_q][s] != SLOT_READY) head_done = 1'b0;
    end

    assign out_valid = (count_q != '0) && head_done;
    assign issue     = out_valid && out_ready;
    assign in_ready  = (count_q != (PTR_W+1)'(DEPTH)) || issue;
    assign accept    = in_valid && in_ready;
    assign out_tag   = tag_q[head_q];

    generate
        for (genvar s = 0; s < NSRC; s++) begin : g_out
            assign out_ops[s*VW +: VW] = dat_q[head_q][s];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
            for (int e = 0; e < DEPTH; e++)
                for (int s = 0; s < NSRC; s++) st_q[e][s] <= SLOT_READY;
        end else begin
            for (int e = 0; e < DEPTH; e++) begin
                for (int s = 0; s < NSRC; s++) begin
                    if (st_q[e][s] == SLOT_INFL) begin
                        st_q[e][s]  <= SLOT_READY;
                        dat_q[e][s] <= bank_rd_data[int'(idx_q[e][s][BANK_W-1:0])*VW +: VW];
                    end else if (gnt_slot[e][s]) begin
                        st_q[e][s] <= SLOT_INFL;
                    end
                end
            end
            if (issue) head_q <= head_q + 1'b1;
            if (accept) begin
                tail_q        <= tail_q + 1'b1;
                tag_q[tail_q] <= in_tag;
                for (int s = 0; s < NSRC; s++) begin
                    idx_q[tail_q][s] <= in_src_idx[s*IDX_W +: IDX_W];
                    if (!in_src_vld[s]) begin
                        st_q[tail_q][s]  <= SLOT_READY;
                        dat_q[tail_q][s] <= '0;
                    end else if (rfc_hit[s]) begin
                        st_q[tail_q][s]  <= SLOT_READY;
                        dat_q[tail_q][s] <= rfc_data[s*VW +: VW];
                    end else begin
                        st_q[tail_q][s]  <= SLOT_NEED;
                    end
                end
            end
            count_q <= count_q + {{PTR_W{1'b0}}, accept} - {{PTR_W{1'b0}}, issue};
        end
    end

    opc_conflict_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .lost (lost),
        .cnt  (conflict_cycles)
    );

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count_q <= (PTR_W+1)'(DEPTH)); // R8
    AST_FULL_STALLS_INPUT: assert property (@(posedge clk) disable iff (rst)
        (count_q == (PTR_W+1)'(DEPTH) && !out_ready) |-> !in_ready); // R8
    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_tag))); // R7

    generate
        for (genvar e = 0; e < DEPTH; e++) begin : g_chk_e
            for (genvar s = 0; s < NSRC; s++) begin : g_chk_s
                AST_READ_LANDS: assert property (@(posedge clk) disable iff (rst)
                    st_q[e][s] == SLOT_INFL |=> st_q[e][s] == SLOT_READY); // R5
                AST_HIT_SKIPS_BANK: assert property (@(posedge clk) disable iff (rst)
                    (accept && tail_q == PTR_W'(e) && in_src_vld[s] && rfc_hit[s])
                    |=> st_q[e][s] == SLOT_READY); // R4
            end
        end
    endgenerate
endmodule

// File: tb/sim_opc_collector.sv
`timescale 1ns/1ps
module sim_opc_collector;
    localparam int LANES = 2, LANE_W = 8, NREGS = 512, NBANKS = 4, NSRC = 3;
    localparam int DEPTH = 4, TAG_W = 8, CNT_W = 16;
    localparam int VW = LANES * LANE_W, IDX_W = 9, ROW_W = 7;
    localparam int HIT_BASE = 480;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, out_ready = 1'b0;
    logic in_ready, out_valid;
    logic [TAG_W-1:0] in_tag = '0, out_tag;
    logic [NSRC-1:0] in_src_vld = '0, rfc_hit = '0;
    logic [NSRC*IDX_W-1:0] in_src_idx = '0;
    logic [NSRC*VW-1:0] rfc_data = '0, out_ops;
    logic [NBANKS-1:0] bank_rd_en;
    logic [NBANKS*ROW_W-1:0] bank_rd_idx;
    logic [NBANKS*VW-1:0] bank_rd_data = '0;
    logic [CNT_W-1:0] conflict_cycles;

    always #4 clk = ~clk;

    opc_collector #(.LANES(LANES), .LANE_W(LANE_W), .NREGS(NREGS), .NBANKS(NBANKS),
        .NSRC(NSRC), .DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_tag(in_tag),
        .in_src_vld(in_src_vld), .in_src_idx(in_src_idx), .rfc_hit(rfc_hit),
        .rfc_data(rfc_data), .bank_rd_en(bank_rd_en), .bank_rd_idx(bank_rd_idx),
        .bank_rd_data(bank_rd_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_tag(out_tag), .out_ops(out_ops), .conflict_cycles(conflict_cycles));

    int errors = 0, checks = 0, wd = 0;

    function automatic logic [VW-1:0] bank_val(input int idx);
        return VW'(idx * 37 + 5);
    endfunction
    function automatic logic [VW-1:0] cache_val(input int idx);
        return bank_val(idx) ^ '1;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Bank memory: answer each request one cycle later.
    int prev_row [NBANKS];
    initial for (int b = 0; b < NBANKS; b++) prev_row[b] = 0;
    always @(negedge clk) begin
        for (int b = 0; b < NBANKS; b++) begin
            bank_rd_data[b*VW +: VW] <= bank_val(prev_row[b] * NBANKS + b);
            prev_row[b] <= int'(bank_rd_idx[b*ROW_W +: ROW_W]);
        end
    end

    // Behavioural reference: position 0 is the oldest instruction.
    int m_cnt = 0, m_conf = 0;
    int m_tag [DEPTH];
    int m_st  [DEPTH][NSRC];   // 0 present, 1 waiting, 2 read in flight
    int m_idx [DEPTH][NSRC];
    int m_kind[DEPTH][NSRC];   // 0 bank, 1 cache, 2 unused
    logic [VW-1:0] m_dat [DEPTH][NSRC];
    int gage [NBANKS], gslot [NBANKS];
    bit exp_ready, head_ok, m_lost;
    int tagc = 0;

    task automatic model_check();
        head_ok = (m_cnt > 0);
        if (m_cnt > 0) for (int s = 0; s < NSRC; s++) if (m_st[0][s] != 0) head_ok = 0;
        exp_ready = (m_cnt < DEPTH) || (head_ok && out_ready);
        chk(in_ready === exp_ready, "R8", "in_ready", longint'(in_ready), longint'(exp_ready));
        chk(out_valid === head_ok, "R7", "out_valid", longint'(out_valid), longint'(head_ok));
        if (head_ok) begin
            chk(out_tag === TAG_W'(m_tag[0]), "R7", "out_tag", longint'(out_tag), longint'(m_tag[0]));
            for (int s = 0; s < NSRC; s++)
                chk(out_ops[s*VW +: VW] === m_dat[0][s],
                    m_kind[0][s] == 1 ? "R4" : (m_kind[0][s] == 2 ? "R6" : "R5"),
                    "out_ops slot", longint'(out_ops[s*VW +: VW]), longint'(m_dat[0][s]));
        end
        for (int b = 0; b < NBANKS; b++) begin
            gage[b] = -1; gslot[b] = -1;
            for (int a = 0; a < m_cnt; a++)
                for (int s = 0; s < NSRC; s++)
                    if (gage[b] < 0 && m_st[a][s] == 1 && m_idx[a][s] % NBANKS == b) begin
                        gage[b] = a; gslot[b] = s;
                    end
            chk(bank_rd_en[b] === (gage[b] >= 0), "R3", "bank_rd_en",
                longint'(bank_rd_en[b]), longint'(gage[b] >= 0));
            if (gage[b] >= 0)
                chk(bank_rd_idx[b*ROW_W +: ROW_W] === ROW_W'(m_idx[gage[b]][gslot[b]] / NBANKS),
                    "R1", "bank_rd_idx", longint'(bank_rd_idx[b*ROW_W +: ROW_W]),
                    longint'(m_idx[gage[b]][gslot[b]] / NBANKS));
        end
        chk(conflict_cycles === CNT_W'(m_conf), "R9", "conflict_cycles",
            longint'(conflict_cycles), longint'(m_conf));
        m_lost = 0;
        for (int a = 0; a < m_cnt; a++)
            for (int s = 0; s < NSRC; s++)
                if (m_st[a][s] == 1) begin
                    int bk = m_idx[a][s] % NBANKS;
                    if (!(gage[bk] == a && gslot[bk] == s)) m_lost = 1;
                end
    endtask

    task automatic model_update(input bit v, input int ix [NSRC], input bit [NSRC-1:0] vld);
        for (int a = 0; a < m_cnt; a++)
            for (int s = 0; s < NSRC; s++)
                if (m_st[a][s] == 2) begin m_st[a][s] = 0; m_dat[a][s] = bank_val(m_idx[a][s]); end
        for (int b = 0; b < NBANKS; b++) if (gage[b] >= 0) m_st[gage[b]][gslot[b]] = 2;
        if (m_lost) m_conf++;
        if (head_ok && out_ready) begin
            for (int a = 0; a < DEPTH - 1; a++) begin
                m_tag[a] = m_tag[a+1];
                for (int s = 0; s < NSRC; s++) begin
                    m_st[a][s] = m_st[a+1][s]; m_idx[a][s] = m_idx[a+1][s];
                    m_kind[a][s] = m_kind[a+1][s]; m_dat[a][s] = m_dat[a+1][s];
                end
            end
            m_cnt--;
        end
        if (v && exp_ready) begin
            m_tag[m_cnt] = tagc % 256;
            for (int s = 0; s < NSRC; s++) begin
                m_idx[m_cnt][s] = ix[s];
                if (!vld[s]) begin
                    m_st[m_cnt][s] = 0; m_dat[m_cnt][s] = '0; m_kind[m_cnt][s] = 2;
                end else if (ix[s] >= HIT_BASE) begin
                    m_st[m_cnt][s] = 0; m_dat[m_cnt][s] = cache_val(ix[s]); m_kind[m_cnt][s] = 1;
                end else begin
                    m_st[m_cnt][s] = 1; m_kind[m_cnt][s] = 0;
                end
            end
            m_cnt++;
            tagc++;
        end
    endtask

    task automatic cyc(input bit v, input int i0, input int i1, input int i2,
                       input bit [NSRC-1:0] vld, input bit ordy);
        int ix [NSRC];
        ix[0] = i0; ix[1] = i1; ix[2] = i2;
        in_valid  = v;
        in_tag    = TAG_W'(tagc);
        out_ready = ordy;
        for (int s = 0; s < NSRC; s++) begin
            in_src_idx[s*IDX_W +: IDX_W] = IDX_W'(ix[s]);
            in_src_vld[s] = vld[s];
            rfc_hit[s]    = vld[s] && (ix[s] >= HIT_BASE);
            rfc_data[s*VW +: VW] = cache_val(ix[s]);
        end
        #1 model_check();
        @(posedge clk);
        model_update(v, ix, vld);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 50000) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    logic [31:0] lf = 32'h1234_5677;
    int base;

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1;
        // R10: empty after reset
        chk(in_ready === 1'b1, "R10", "in_ready", longint'(in_ready), 1);
        chk(out_valid === 1'b0, "R10", "out_valid", longint'(out_valid), 0);
        chk(bank_rd_en === '0, "R10", "bank_rd_en", longint'(bank_rd_en), 0);
        chk(conflict_cycles === '0, "R9", "conflict_cycles", longint'(conflict_cycles), 0);
        rst = 1'b0;
        @(negedge clk);

        // Spaced instructions on three distinct banks: no lost cycles (R9)
        base = int'(conflict_cycles);
        for (int k = 0; k < 6; k++) begin
            cyc(1, 8*k, 8*k + 1, 8*k + 2, 3'b111, 1);
            repeat (5) cyc(0, 0, 0, 0, 3'b000, 1);
        end
        chk(int'(conflict_cycles) - base == 0, "R9", "conflict-free delta",
            longint'(int'(conflict_cycles) - base), 0);

        // Spaced instructions with all three sources in bank 0: two lost cycles each (R2, R9)
        base = int'(conflict_cycles);
        for (int k = 0; k < 4; k++) begin
            cyc(1, 16*k, 16*k + 4, 16*k + 8, 3'b111, 1);
            repeat (6) cyc(0, 0, 0, 0, 3'b000, 1);
        end
        chk(int'(conflict_cycles) - base == 8, "R9", "conflicting delta",
            longint'(int'(conflict_cycles) - base), 8);

        // Two entries contending for bank 1 with the ALU stalled (R3)
        cyc(1, 1, 5, 9, 3'b111, 0);
        cyc(1, 13, 17, 21, 3'b111, 0);
        repeat (10) cyc(0, 0, 0, 0, 3'b000, 0);
        repeat (4) cyc(0, 0, 0, 0, 3'b000, 1);

        // Cache hits and unused slots (R4, R6)
        cyc(1, 500, 3, 481, 3'b111, 1);
        cyc(1, 7, 200, 300, 3'b001, 1);
        cyc(1, 511, 490, 480, 3'b111, 1);
        cyc(1, 0, 0, 0, 3'b000, 1);
        repeat (6) cyc(0, 0, 0, 0, 3'b000, 1);

        // Fill the queue, then accept and issue together (R8)
        for (int k = 0; k < 8; k++) cyc(1, 4*k + 2, 4*k + 3, 4*k + 6, 3'b111, 0);
        #1 chk(in_ready === 1'b0, "R8", "full in_ready", longint'(in_ready), 0);
        for (int k = 0; k < 12; k++) cyc(1, 4*k + 1, 4*k + 5, 4*k + 2, 3'b111, 1);
        repeat (8) cyc(0, 0, 0, 0, 3'b000, 1);

        // Mixed traffic
        for (int k = 0; k < 1500; k++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            cyc(lf[0] | lf[1], int'(lf[10:2]), int'(lf[19:11]), int'(lf[28:20]),
                {lf[29] | lf[30], lf[31] | lf[2], lf[3] | lf[4]}, lf[8:7] != 2'b00);
        end
        repeat (20) cyc(0, 0, 0, 0, 3'b000, 1);
        chk(out_valid === 1'b0, "R7", "drained out_valid", longint'(out_valid), 0);

        summary();
        $finish;
    end
endmodule